// File: doc/BRIEF.md
# Event Fragment Router with Busy Back-Signal

This block sits between an event builder and two consumers. Formatted 32-bit event words, with a flag on the last word of each event, enter an internal FIFO. In data-taking mode the FIFO head drives an output link that may withhold its ready signal to apply back-pressure. A prescaled subset of events is also copied to a monitoring port. The copy is taken only on cycles when the link itself accepts a word, so it can never slow the link. In calibration mode the link output stays silent and every event goes to the monitoring port, cut into fixed-size frames.

The FIFO fill is compared against two programmable levels to drive a busy signal toward the trigger source. Busy rises at the upper level and falls only below the lower one. Once its configuration inputs are set, the router runs with no processor involvement. The mode input may change only while the FIFO is empty and no event or frame is in progress.

Top module: `efr_router`

## Requirements
- R1: While reset is held and right after it, inReady is 1, busy is 0, linkValid is 0, monValid is 0 and dropCount is 0.
- R2: In data-taking mode (calMode=0) every input word leaves on the link in arrival order, with linkLast equal to the word's inLast. A word is transferred on a clock edge where linkValid and linkReady are both 1.
- R3: While linkReady is 0, linkValid, linkData and linkLast hold their values and input words accumulate. inReady is 0 exactly when the FIFO holds DEPTH words. When linkReady returns, the held word and all words behind it leave with none lost or repeated.
- R4: Busy becomes 1 one cycle after the fill reaches busyOnLevel or more. It becomes 0 one cycle after the fill falls below busyOffLevel. Between the two levels it keeps its value.
- R5: In calibration mode (calMode=1) linkValid is never 1, and input words go to the monitoring port under the monValid/monReady handshake.
- R6: In calibration mode the monitoring output is divided into frames of FRAME_WORDS words, and monLast is 1 on the final word of each frame. An event that ends mid-frame is followed by pad words with data 0 and monPad=1 until the frame is full. An event that ends exactly on a frame boundary gets no padding.
- R7: In data-taking mode, events are numbered from 1 after reset. Event k is copied to the monitoring port when prescale is non-zero and k is a multiple of prescale; prescale=0 copies nothing. A copied word appears with monValid=1 only on the cycle it transfers on the link, with monLast equal to the word's last flag.
- R8: monReady never affects the link path. If monReady is 0 when the first word of a selected event transfers, that event is not copied and dropCount (saturating) increments by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| calMode | input | 1 | 1 = calibration mode, 0 = data-taking mode |
| prescale | input | PS_W | Copy every Nth event to monitor; 0 disables |
| busyOnLevel | input | FILL_W | Fill at or above which busy rises |
| busyOffLevel | input | FILL_W | Fill below which busy falls |
| inData | input | DATA_W | Incoming event word |
| inLast | input | 1 | Marks the last word of an event |
| inValid | input | 1 | Incoming word valid |
| inReady | output | 1 | FIFO can accept a word |
| linkData | output | DATA_W | Link output word |
| linkLast | output | 1 | Last word of event on link |
| linkValid | output | 1 | Link word valid |
| linkReady | input | 1 | Link accepts a word (0 = back-pressure) |
| monData | output | DATA_W | Monitor output word (0 for pad words) |
| monLast | output | 1 | End of event (data mode) or end of frame (calibration mode) |
| monPad | output | 1 | Current monitor word is padding |
| monValid | output | 1 | Monitor word valid |
| monReady | input | 1 | Monitor accepts a word |
| busy | output | 1 | Stop-triggers signal toward the trigger source |
| dropCount | output | CNT_W | Count of skipped monitor copies, saturating |

## Verification
The bench builds the router with a 16-entry FIFO, 8-word frames and 8-bit prescale and counter widths. The small FIFO lets one stalled event fill it completely. That reaches the full condition and both hysteresis levels within a few dozen cycles. The short frame makes the mid-frame pad, the frame-spanning event and the exact-boundary event all cheap to exercise. Prescale 2 over a six-event table covers copied, uncopied and dropped events in one pass.

// File: rtl/efr_pkg.sv
package efr_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic pop;   // consume FIFO head
    logic pad;   // monitor output carries a pad word
  } efr_dp_strb_t;
endpackage

// File: rtl/efr_datapath.sv
module efr_datapath
  import efr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  parameter int FILL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  input  logic              inValid,
  output logic              inReady,
  input  efr_dp_strb_t      strb,
  output logic              headValid,
  output logic              headLast,
  output logic [FILL_W-1:0] fill,
  output logic [DATA_W-1:0] linkData,
  output logic [DATA_W-1:0] monData
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int ENTRY_W = DATA_W + 1;

  logic [ENTRY_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0]  wrPtr, rdPtr;
  logic [FILL_W-1:0]  count;
  logic               push, pop;
  logic [ENTRY_W-1:0] head;

  assign inReady   = (count != FILL_W'(DEPTH));
  assign push      = inValid && inReady;
  assign headValid = (count != '0);
  assign pop       = strb.pop && headValid;
  assign head      = store[rdPtr];
  assign headLast  = head[DATA_W];
  assign linkData  = head[DATA_W-1:0];
  assign monData   = strb.pad ? '0 : head[DATA_W-1:0];
  assign fill      = count;

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= {inLast, inData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/efr_ctrl.sv
module efr_ctrl
  import efr_pkg::*;
#(
  parameter int FRAME_WORDS = 256,
  parameter int PS_W        = 16,
  parameter int FILL_W      = 10,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calMode,
  input  logic [PS_W-1:0]   prescale,
  input  logic [FILL_W-1:0] busyOnLevel,
  input  logic [FILL_W-1:0] busyOffLevel,
  input  logic              headValid,
  input  logic              headLast,
  input  logic [FILL_W-1:0] fill,
  input  logic              linkReady,
  input  logic              monReady,
  output efr_dp_strb_t      strb,
  output logic              linkValid,
  output logic              monValid,
  output logic              monLast,
  output logic              busy,
  output logic [CNT_W-1:0]  dropCount
);
  localparam int FC_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;

  logic            midEvent, copyFlag, padding;
  logic [FC_W-1:0] frameCnt;
  logic [PS_W-1:0] evCnt;
  logic            frameEnd, startHit, copyNow, monXfer;

  assign frameEnd = (frameCnt == FC_W'(FRAME_WORDS - 1));
  assign startHit = (prescale != '0) && (evCnt == prescale - 1'b1);

  always_comb begin
    strb      = '0;
    linkValid = 1'b0;
    monValid  = 1'b0;
    monLast   = 1'b0;
    copyNow   = 1'b0;
    if (calMode) begin
      monLast = frameEnd;
      if (padding) begin
        monValid = 1'b1;
        strb.pad = 1'b1;
      end else begin
        monValid = headValid;
        strb.pop = headValid && monReady;
      end
    end else begin
      linkValid = headValid;
      strb.pop  = headValid && linkReady;
      copyNow   = startHit && monReady;
      monValid  = strb.pop && (midEvent ? copyFlag : copyNow);
      monLast   = headLast;
    end
  end

  assign monXfer = monValid && monReady;

  // event tracking and prescale in data-taking mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      midEvent  <= 1'b0;
      copyFlag  <= 1'b0;
      evCnt     <= '0;
      dropCount <= '0;
    end else if (!calMode && strb.pop) begin
      midEvent <= !headLast;
      if (!midEvent) begin
        copyFlag <= copyNow;
        if (startHit && !monReady && dropCount != '1)
          dropCount <= dropCount + 1'b1;
      end
      if (headLast)
        evCnt <= (prescale == '0 || startHit) ? '0 : evCnt + 1'b1;
    end
  end

  // framing in calibration mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
      padding  <= 1'b0;
    end else if (calMode && monXfer) begin
      frameCnt <= frameEnd ? '0 : frameCnt + 1'b1;
      if (padding) begin
        if (frameEnd) padding <= 1'b0;
      end else if (headLast && !frameEnd) begin
        padding <= 1'b1;
      end
    end
  end

  // busy with hysteresis
  always_ff @(posedge clk) begin
    if (!rstN) busy <= 1'b0;
    else if (busy) busy <= !(fill < busyOffLevel);
    else busy <= (fill >= busyOnLevel);
  end
endmodule

// File: rtl/efr_router.sv
module efr_router
  import efr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 512,
  parameter int FRAME_WORDS = 256,
  parameter int PS_W        = 16,
  parameter int CNT_W       = 16,
  localparam int FILL_W     = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calMode,
  input  logic [PS_W-1:0]   prescale,
  input  logic [FILL_W-1:0] busyOnLevel,
  input  logic [FILL_W-1:0] busyOffLevel,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  input  logic              inValid,
  output logic              inReady,
  output logic [DATA_W-1:0] linkData,
  output logic              linkLast,
  output logic              linkValid,
  input  logic              linkReady,
  output logic [DATA_W-1:0] monData,
  output logic              monLast,
  output logic              monPad,
  output logic              monValid,
  input  logic              monReady,
  output logic              busy,
  output logic [CNT_W-1:0]  dropCount
);
  efr_dp_strb_t      strb;
  logic              headValid, headLast;
  logic [FILL_W-1:0] fillLevel;

  efr_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FILL_W(FILL_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .inData(inData), .inLast(inLast), .inValid(inValid), .inReady(inReady),
    .strb(strb), .headValid(headValid), .headLast(headLast), .fill(fillLevel),
    .linkData(linkData), .monData(monData)
  );

  efr_ctrl #(.FRAME_WORDS(FRAME_WORDS), .PS_W(PS_W), .FILL_W(FILL_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .calMode(calMode), .prescale(prescale),
    .busyOnLevel(busyOnLevel), .busyOffLevel(busyOffLevel),
    .headValid(headValid), .headLast(headLast), .fill(fillLevel),
    .linkReady(linkReady), .monReady(monReady), .strb(strb),
    .linkValid(linkValid), .monValid(monValid), .monLast(monLast),
    .busy(busy), .dropCount(dropCount)
  );

  assign linkLast = headLast;
  assign monPad   = strb.pad;
endmodule

// File: rtl/efr_router_chk.sv
module efr_router_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  parameter int FILL_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              calMode,
  input logic [FILL_W-1:0] busyOnLevel,
  input logic [FILL_W-1:0] busyOffLevel,
  input logic [FILL_W-1:0] fillLevel,
  input logic              inReady,
  input logic              linkValid,
  input logic              linkReady,
  input logic [DATA_W-1:0] linkData,
  input logic              linkLast,
  input logic              monValid,
  input logic              monPad,
  input logic [DATA_W-1:0] monData,
  input logic              busy
);
  // R5
  cal_link_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    calMode |-> !linkValid);

  // R3
  link_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && !linkReady && !calMode) |=> (linkValid && $stable(linkData) && $stable(linkLast)));

  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == FILL_W'(DEPTH)) |-> !inReady);

  // R4
  busy_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyOffLevel <= busyOnLevel && fillLevel >= busyOnLevel) |=> busy);

  // R4
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel < busyOffLevel) |=> !busy);

  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (monValid && monPad) |-> (monData == '0));

  // R8
  copy_rides_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    (monValid && !calMode) |-> (linkValid && linkReady));
endmodule

bind efr_router efr_router_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (.*);

// File: tb/efr_router_bench.sv
module efr_router_bench;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int FRAME  = 8;
  localparam int PS_W   = 8;
  localparam int CNT_W  = 8;
  localparam int FILL_W = $clog2(DEPTH) + 1;

  // event table: {length[7:0], monReady, expect copy}
  localparam int NEV = 6;
  localparam logic [9:0] VEC [NEV] = '{
    {8'd3, 1'b1, 1'b0}, {8'd1, 1'b1, 1'b1}, {8'd4, 1'b1, 1'b0},
    {8'd2, 1'b0, 1'b0}, {8'd5, 1'b1, 1'b0}, {8'd2, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN;
  logic calMode;
  logic [PS_W-1:0] prescale;
  logic [FILL_W-1:0] busyOnLevel, busyOffLevel;
  logic [DATA_W-1:0] inData;
  logic inLast, inValid, inReady;
  logic [DATA_W-1:0] linkData, monData;
  logic linkLast, linkValid, linkReady;
  logic monLast, monPad, monValid, monReady, busy;
  logic [CNT_W-1:0] dropCount;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [DATA_W:0]   linkLog [256];
  logic [DATA_W+1:0] monLog  [256];
  int linkN = 0;
  int monN  = 0;

  always #4 clk = ~clk;

  efr_router #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FRAME_WORDS(FRAME),
               .PS_W(PS_W), .CNT_W(CNT_W)) u_efr_router (
    .clk(clk), .rstN(rstN), .calMode(calMode), .prescale(prescale),
    .busyOnLevel(busyOnLevel), .busyOffLevel(busyOffLevel),
    .inData(inData), .inLast(inLast), .inValid(inValid), .inReady(inReady),
    .linkData(linkData), .linkLast(linkLast), .linkValid(linkValid), .linkReady(linkReady),
    .monData(monData), .monLast(monLast), .monPad(monPad), .monValid(monValid),
    .monReady(monReady), .busy(busy), .dropCount(dropCount)
  );

  // transfer logger, samples between edges
  always @(negedge clk) begin
    if (rstN) begin
      if (linkValid && linkReady) begin
        linkLog[linkN] = {linkLast, linkData};
        linkN++;
      end
      if (monValid && monReady) begin
        monLog[monN] = {monPad, monLast, monData};
        monN++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word(input int ev, input int i);
    return {ev[15:0], i[15:0]};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendEvent(input int ev, input int len);
    logic acc;
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1;
      inData  = word(ev, i);
      inLast  = (i == len - 1);
      do begin
        @(negedge clk);
        acc = inReady;
        @(posedge clk);
        #1;
      end while (!acc);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  task automatic popN(input int n);
    linkReady = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    linkReady = 1'b0;
  endtask

  // checks one logged link word
  task automatic expLink(input int idx, input int ev, input int i, input bit last, input string tag);
    logic [DATA_W:0] e;
    e = {last, word(ev, i)};
    check(linkLog[idx] == e, tag, linkLog[idx], e);
  endtask

  task automatic expMon(input int idx, input bit pad, input bit last,
                        input logic [DATA_W-1:0] d, input string tag);
    logic [DATA_W+1:0] e;
    e = {pad, last, d};
    check(monLog[idx] == e, tag, monLog[idx], e);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ls, ms, pos;
    rstN = 1'b0; calMode = 1'b0; prescale = 8'd2;
    busyOnLevel = 5'd12; busyOffLevel = 5'd4;
    inData = '0; inLast = 1'b0; inValid = 1'b0;
    linkReady = 1'b1; monReady = 1'b1;
    idle(3);
    @(negedge clk);
    // R1 during reset
    check(inReady && !busy && !linkValid && !monValid && dropCount == 0,
          "R1 reset state", {inReady, busy, linkValid, monValid}, 4'b1000);
    @(posedge clk); #1;
    rstN = 1'b1;
    idle(1);
    @(negedge clk);
    check(inReady && !busy && !linkValid && !monValid && dropCount == 0,
          "R1 after reset", {inReady, busy, linkValid, monValid}, 4'b1000);
    @(posedge clk); #1;

    // table walk: data mode, prescale 2
    for (int v = 0; v < NEV; v++) begin
      monReady = VEC[v][1];
      sendEvent(v + 1, int'(VEC[v][9:2]));
      idle(6);
    end
    monReady = 1'b1;
    // R2 link order and last flags
    pos = 0;
    for (int v = 0; v < NEV; v++)
      for (int i = 0; i < int'(VEC[v][9:2]); i++) begin
        expLink(pos, v + 1, i, i == int'(VEC[v][9:2]) - 1, "R2 link word");
        pos++;
      end
    check(linkN == pos, "R2 link count", linkN, pos);
    // R7 copies of events 2 and 6 only
    pos = 0;
    for (int v = 0; v < NEV; v++)
      if (VEC[v][0])
        for (int i = 0; i < int'(VEC[v][9:2]); i++) begin
          expMon(pos, 1'b0, i == int'(VEC[v][9:2]) - 1, word(v + 1, i), "R7 copy word");
          pos++;
        end
    check(monN == pos, "R7 copy count", monN, pos);
    // R8 skipped copy counted
    check(dropCount == 1, "R8 dropCount", dropCount, 1);

    // R7 prescale 0 copies nothing
    prescale = 8'd0;
    ms = monN;
    sendEvent(10, 2);
    sendEvent(11, 3);
    idle(6);
    check(monN == ms, "R7 prescale zero", monN, ms);

    // R3/R4 back-pressure and busy hysteresis
    linkReady = 1'b0;
    ls = linkN;
    sendEvent(20, DEPTH);
    idle(2);
    @(negedge clk);
    check(busy == 1'b1, "R4 busy set", busy, 1);
    check(inReady == 1'b0, "R3 full stall", inReady, 0);
    check(linkValid && linkData == word(20, 0), "R3 head held", linkData, word(20, 0));
    @(posedge clk); #1;
    popN(8);
    idle(2);
    check(busy == 1'b1, "R4 hysteresis hold", busy, 1);
    check(linkN - ls == 8, "R3 partial drain", linkN - ls, 8);
    popN(5);
    idle(2);
    check(busy == 1'b0, "R4 busy clear", busy, 0);
    linkReady = 1'b1;
    idle(6);
    check(linkN - ls == DEPTH, "R3 drain count", linkN - ls, DEPTH);
    for (int i = 0; i < DEPTH; i++)
      expLink(ls + i, 20, i, i == DEPTH - 1, "R3 resume order");

    // calibration mode framing
    calMode = 1'b1;
    ls = linkN;
    ms = monN;
    sendEvent(30, 3);
    idle(12);
    check(monN - ms == FRAME, "R6 padded frame size", monN - ms, FRAME);
    for (int i = 0; i < 3; i++)
      expMon(ms + i, 1'b0, 1'b0, word(30, i), "R5 cal data word");
    for (int i = 3; i < FRAME; i++)
      expMon(ms + i, 1'b1, i == FRAME - 1, '0, "R6 pad word");
    ms = monN;
    sendEvent(31, 10);
    idle(20);
    check(monN - ms == 2 * FRAME, "R6 spanning size", monN - ms, 2 * FRAME);
    for (int i = 0; i < 10; i++)
      expMon(ms + i, 1'b0, i == FRAME - 1, word(31, i), "R6 spanning data");
    for (int i = 10; i < 2 * FRAME; i++)
      expMon(ms + i, 1'b1, i == 2 * FRAME - 1, '0, "R6 spanning pad");
    ms = monN;
    sendEvent(32, FRAME);
    idle(12);
    check(monN - ms == FRAME, "R6 exact frame no pad", monN - ms, FRAME);
    for (int i = 0; i < FRAME; i++)
      expMon(ms + i, 1'b0, i == FRAME - 1, word(32, i), "R6 exact frame word");
    check(linkN == ls, "R5 link silent", linkN, ls);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule